// File: doc/BRIEF.md
# Interrupt acceptance and vectoring controller

This block sits beside the sequencer of an 8-bit processor core and decides, at each instruction boundary, whether the core takes an interrupt and where execution continues. It holds the two interrupt-enable flip-flops, the maskable response mode and the interrupt page register. It also keeps a latch that captures a falling edge on the non-maskable request line.

The core reports the end of every instruction with a one-clock boundary strobe. While halted, the core runs refresh no-op cycles and raises the strobe on each of their final clocks. Control events decoded from the finishing instruction are presented in the same clock as its strobe: enable, disable, return-from-NMI, mode select, a load of A from the page or refresh register, and a load of the page register. When a request is accepted, the block raises a one-clock strobe and presents the next address. That address is a fixed restart location, a vector-table pointer, or a flag telling the core to execute the byte the device drives onto the data bus.

Top module: `irq_vector_ctl`

## Requirements
- R1: After synchronous reset both enable flags read 0, the mode reads 0 and no accept strobe is raised. The page register is cleared: a mode-2 accept right after reset gives a pointer whose high byte is 00h.
- R2: Control events take effect only in a clock where `insn_end` is 1. Enable sets both flags and disable clears both.
- R3: Accepting a maskable request clears both flags. Accepting a non-maskable request clears only the first flag and leaves the second as it was. Return-from-NMI copies the second flag into the first.
- R4: A load of A from the page or refresh register sets `pv_flag` to the value the second flag had before that boundary.
- R5: A falling edge of `nmi_n` is held pending until the next boundary, even after the line returns high. At that boundary it is accepted whatever the flags and `busreq`, with target 0066h, and the pending state is then cleared.
- R6: When a non-maskable request is pending at a boundary, only the non-maskable request is accepted, even if a maskable request is also valid.
- R7: A maskable request is accepted only at a boundary with `int_n` 0, the first flag set and `busreq` 0. It is never accepted at the boundary that carries enable or disable. It is not accepted at the boundary of the instruction that follows an enable; the boundary after that is the first one at which it can be taken.
- R8: A mode-1 accept gives target 0038h with `from_bus` 0. A mode-0 accept gives `from_bus` 1 and target 0000h.
- R9: A mode-2 accept gives target {page register, `vec_byte`[7:1], 0}. The page register and the mode used are the values held before that boundary.
- R10: `nmi_take` and `int_take` are high for exactly one clock, one clock after the accepting boundary edge, and never together.
- R11: The mode select codes 0, 1 and 2 set that mode. Code 3 leaves the mode unchanged.
- R12: The same arbitration applies at the boundary strobes of the halted no-op cycles, so a request ends the halt one clock after such a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Maskable request, active low level |
| busreq | input | 1 | Bus request active, blocks maskable accept |
| insn_end | input | 1 | Instruction boundary strobe (also each halted no-op) |
| ev_ei | input | 1 | Finishing instruction enables interrupts |
| ev_di | input | 1 | Finishing instruction disables interrupts |
| ev_retn | input | 1 | Finishing instruction returns from NMI |
| ev_im | input | 1 | Finishing instruction selects a mode |
| im_code | input | 2 | Requested mode (0, 1, 2; 3 ignored) |
| ev_ld_air | input | 1 | Finishing instruction loads A from page or refresh register |
| ev_i_load | input | 1 | Finishing instruction loads the page register |
| i_data | input | 8 | Value for the page register |
| vec_byte | input | 8 | Vector byte from the interrupting device |
| nmi_take | output | 1 | Non-maskable accept strobe |
| int_take | output | 1 | Maskable accept strobe |
| from_bus | output | 1 | Execute the data-bus byte (mode 0) |
| target | output | 16 | Restart address or table pointer |
| iff1 | output | 1 | First enable flag |
| iff2 | output | 1 | Second enable flag |
| im_mode | output | 2 | Current mode |
| pv_flag | output | 1 | Parity/overflow value from the last load of A from I or R |

## Verification
The assertions assume that event strobes appear only together with `insn_end` and that at most one flag-changing event (enable, disable or return) arrives at a boundary. The random stimulus draws a single event code per step and drives it only on boundary clocks. Requests, bus request and boundaries are drawn independently, so pending-edge, blocked and overlapping cases all occur.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        IM_BUSOP = 2'd0,
        IM_FIXED = 2'd1,
        IM_TABLE = 2'd2
    } im_mode_e;

    localparam logic [ADDR_W-1:0] NMI_VEC   = 16'h0066;
    localparam logic [ADDR_W-1:0] FIXED_VEC = 16'h0038;

    typedef struct packed {
        logic              ei;
        logic              di;
        logic              retn;
        logic              im_set;
        logic [1:0]        im_code;
        logic              ld_air;
        logic              i_load;
        logic [DATA_W-1:0] i_data;
    } ctl_ev_t;

    function automatic logic [ADDR_W-1:0] table_ptr(input logic [DATA_W-1:0] page,
                                                    input logic [DATA_W-1:0] vec);
        return {page, vec[DATA_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic clear,
    output logic pend_now
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall     = prev_q & ~nmi_n;
    assign pend_now = pend_q | fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_n;
            if (clear) pend_q <= 1'b0;
            else if (fall) pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd,
    input  ctl_ev_t           ev,
    input  logic              acc_nmi,
    input  logic              acc_int,
    output logic              iff1_q,
    output logic              iff2_q,
    output logic              blk_q,
    output im_mode_e          mode_q,
    output logic [DATA_W-1:0] page_q,
    output logic              pv_q
);
    logic n1, n2;

    always_comb begin
        n1 = iff1_q;
        n2 = iff2_q;
        if (bnd) begin
            if (ev.ei) begin
                n1 = 1'b1;
                n2 = 1'b1;
            end else if (ev.di) begin
                n1 = 1'b0;
                n2 = 1'b0;
            end else if (ev.retn) begin
                n1 = iff2_q;
            end
        end
        if (acc_nmi) n1 = 1'b0;
        if (acc_int) begin
            n1 = 1'b0;
            n2 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1_q <= 1'b0;
            iff2_q <= 1'b0;
            blk_q  <= 1'b0;
            mode_q <= IM_BUSOP;
            page_q <= '0;
            pv_q   <= 1'b0;
        end else begin
            iff1_q <= n1;
            iff2_q <= n2;
            if (bnd) begin
                blk_q <= ev.ei;
                if (ev.im_set && ev.im_code != 2'd3) mode_q <= im_mode_e'(ev.im_code);
                if (ev.i_load) page_q <= ev.i_data;
                if (ev.ld_air) pv_q <= iff2_q;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd,
    input  logic              nmi_pend,
    input  logic              int_n,
    input  logic              busreq,
    input  logic              iff1_q,
    input  logic              blk_q,
    input  ctl_ev_t           ev,
    input  im_mode_e          mode_q,
    input  logic [DATA_W-1:0] page_q,
    input  logic [DATA_W-1:0] vec_byte,
    output logic              acc_nmi,
    output logic              acc_int,
    output logic              nmi_take,
    output logic              int_take,
    output logic              from_bus,
    output logic [ADDR_W-1:0] target
);
    logic [ADDR_W-1:0] int_vec;

    assign acc_nmi = bnd & nmi_pend;
    assign acc_int = bnd & ~acc_nmi & ~int_n & iff1_q & ~blk_q
                   & ~ev.ei & ~ev.di & ~busreq;

    always_comb begin
        case (mode_q)
            IM_FIXED: int_vec = FIXED_VEC;
            IM_TABLE: int_vec = table_ptr(page_q, vec_byte);
            default:  int_vec = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_take <= 1'b0;
            int_take <= 1'b0;
            from_bus <= 1'b0;
            target   <= '0;
        end else begin
            nmi_take <= acc_nmi;
            int_take <= acc_int;
            from_bus <= acc_int && (mode_q == IM_BUSOP);
            if (acc_nmi) target <= NMI_VEC;
            else if (acc_int) target <= int_vec;
        end
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_n,
    input  logic              int_n,
    input  logic              busreq,
    input  logic              insn_end,
    input  logic              ev_ei,
    input  logic              ev_di,
    input  logic              ev_retn,
    input  logic              ev_im,
    input  logic [1:0]        im_code,
    input  logic              ev_ld_air,
    input  logic              ev_i_load,
    input  logic [DATA_W-1:0] i_data,
    input  logic [DATA_W-1:0] vec_byte,
    output logic              nmi_take,
    output logic              int_take,
    output logic              from_bus,
    output logic [ADDR_W-1:0] target,
    output logic              iff1,
    output logic              iff2,
    output logic [1:0]        im_mode,
    output logic              pv_flag
);
    ctl_ev_t  ev;
    logic     nmi_pend, acc_nmi, acc_int, blk_q;
    im_mode_e mode_q;
    logic [DATA_W-1:0] page_q;

    assign ev = '{ei: ev_ei, di: ev_di, retn: ev_retn, im_set: ev_im,
                  im_code: im_code, ld_air: ev_ld_air, i_load: ev_i_load,
                  i_data: i_data};
    assign im_mode = mode_q;

    irq_nmi_latch u_nmi (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .clear(acc_nmi), .pend_now(nmi_pend)
    );

    irq_enable_regs u_en (
        .clk(clk), .rst(rst), .bnd(insn_end), .ev(ev),
        .acc_nmi(acc_nmi), .acc_int(acc_int),
        .iff1_q(iff1), .iff2_q(iff2), .blk_q(blk_q),
        .mode_q(mode_q), .page_q(page_q), .pv_q(pv_flag)
    );

    irq_arbiter u_arb (
        .clk(clk), .rst(rst), .bnd(insn_end), .nmi_pend(nmi_pend),
        .int_n(int_n), .busreq(busreq), .iff1_q(iff1), .blk_q(blk_q),
        .ev(ev), .mode_q(mode_q), .page_q(page_q), .vec_byte(vec_byte),
        .acc_nmi(acc_nmi), .acc_int(acc_int),
        .nmi_take(nmi_take), .int_take(int_take),
        .from_bus(from_bus), .target(target)
    );
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk (
    input logic        clk,
    input logic        rst,
    input logic        busreq,
    input logic        insn_end,
    input logic        nmi_take,
    input logic        int_take,
    input logic [15:0] target,
    input logic        iff1,
    input logic        iff2,
    input logic [1:0]  im_mode
);
    // R10
    take_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nmi_take && int_take));

    // R10
    int_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        int_take |=> !int_take);

    // R3
    int_clear_chk: assert property (@(posedge clk) disable iff (rst)
        int_take |-> (!iff1 && !iff2));

    // R3
    nmi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_take |-> !iff1);

    // R5
    nmi_vec_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_take |-> target == 16'h0066);

    // R9
    tbl_even_chk: assert property (@(posedge clk) disable iff (rst)
        (int_take && im_mode == 2'd2) |-> !target[0]);

    // R7
    int_bus_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_take) |-> ($past(insn_end) && !$past(busreq)));
endmodule

bind irq_vector_ctl irq_vector_chk u_chk (
    .clk(clk), .rst(rst), .busreq(busreq), .insn_end(insn_end),
    .nmi_take(nmi_take), .int_take(int_take), .target(target),
    .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
);

// File: tb/irq_vector_ctl_test.sv
module irq_vector_ctl_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_n = 1'b1, int_n = 1'b1, busreq = 1'b0, insn_end = 1'b0;
    logic ev_ei = 0, ev_di = 0, ev_retn = 0, ev_im = 0, ev_ld_air = 0, ev_i_load = 0;
    logic [1:0] im_code = 0;
    logic [7:0] i_data = 0, vec_byte = 0;
    logic nmi_take, int_take, from_bus, iff1, iff2, pv_flag;
    logic [15:0] target;
    logic [1:0] im_mode;

    int tests = 0, fails = 0;

    // bench model state
    bit m1, m2, mblk, mpend, mprev, mpv, mtn, mti, mfb;
    bit [1:0] mmode;
    bit [7:0] mpage;
    bit [15:0] mtgt;

    always #(PERIOD/2) clk = ~clk;

    irq_vector_ctl uut (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .int_n(int_n), .busreq(busreq),
        .insn_end(insn_end), .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
        .ev_im(ev_im), .im_code(im_code), .ev_ld_air(ev_ld_air),
        .ev_i_load(ev_i_load), .i_data(i_data), .vec_byte(vec_byte),
        .nmi_take(nmi_take), .int_take(int_take), .from_bus(from_bus),
        .target(target), .iff1(iff1), .iff2(iff2), .im_mode(im_mode),
        .pv_flag(pv_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m1 = 0; m2 = 0; mblk = 0; mpend = 0; mprev = 1; mpv = 0;
        mtn = 0; mti = 0; mfb = 0; mmode = 0; mpage = 0; mtgt = 0;
    endtask

    function automatic bit [15:0] int_target(bit [1:0] md, bit [7:0] pg, bit [7:0] v);
        if (md == 2'd1) return 16'h0038;
        if (md == 2'd2) return {pg, v[7:1], 1'b0};
        return 16'h0000;
    endfunction

    // ev: 0 none, 1 enable, 2 disable, 3 return-nmi, 4 mode, 5 load A from I/R, 6 page load
    task automatic step(input bit bnd, input bit nm, input bit it, input bit br,
                        input int ev, input bit [1:0] ic, input bit [7:0] id,
                        input bit [7:0] vb, input string tag);
        bit edge_n, tn, ti, n1, n2;
        nmi_n = nm; int_n = it; busreq = br; insn_end = bnd;
        ev_ei = bnd && ev == 1; ev_di = bnd && ev == 2; ev_retn = bnd && ev == 3;
        ev_im = bnd && ev == 4; ev_ld_air = bnd && ev == 5; ev_i_load = bnd && ev == 6;
        im_code = ic; i_data = id; vec_byte = vb;
        edge_n = mprev && !nm;
        mprev = nm;
        tn = bnd && (mpend || edge_n);
        ti = bnd && !tn && !it && m1 && !mblk && ev != 1 && ev != 2 && !br;
        n1 = m1; n2 = m2;
        if (bnd && ev == 1) begin n1 = 1; n2 = 1; end
        if (bnd && ev == 2) begin n1 = 0; n2 = 0; end
        if (bnd && ev == 3) n1 = m2;
        if (tn) n1 = 0;
        if (ti) begin n1 = 0; n2 = 0; end
        if (tn) mtgt = 16'h0066;
        else if (ti) mtgt = int_target(mmode, mpage, vb);
        mfb = ti && mmode == 0;
        if (tn) mpend = 0; else if (edge_n) mpend = 1;
        if (bnd) begin
            mblk = (ev == 1);
            if (ev == 5) mpv = m2;
            if (ev == 4 && ic != 2'd3) mmode = ic;
            if (ev == 6) mpage = id;
        end
        m1 = n1; m2 = n2; mtn = tn; mti = ti;
        @(negedge clk);
        insn_end = 0; ev_ei = 0; ev_di = 0; ev_retn = 0; ev_im = 0;
        ev_ld_air = 0; ev_i_load = 0;
        chk({tag, " nmi_take"}, nmi_take, mtn);
        chk({tag, " int_take"}, int_take, mti);
        chk({tag, " iff1"}, iff1, m1);
        chk({tag, " iff2"}, iff2, m2);
        chk({tag, " mode"}, im_mode, mmode);
        chk({tag, " pv"}, pv_flag, mpv);
        if (mtn || mti) begin
            chk({tag, " target"}, target, mtgt);
            chk({tag, " from_bus"}, from_bus, mfb);
        end
    endtask

    bit done = 0;
    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 iff1", iff1, 0); chk("R1 iff2", iff2, 0);
        chk("R1 mode", im_mode, 0); chk("R1 takes", {nmi_take, int_take}, 0);

        // R1 page cleared: mode 2, enable, then take
        step(1, 1, 1, 0, 4, 2'd2, 0, 0, "R11 set mode2");
        step(1, 1, 1, 0, 1, 0, 0, 0, "R2 enable");
        chk("R2 enable sets both", {iff1, iff2}, 2'b11);
        step(1, 1, 0, 0, 0, 0, 0, 8'h47, "R7 blocked after enable");
        chk("R7 no accept after EI", int_take, 0);
        step(1, 1, 0, 0, 0, 0, 0, 8'h47, "R7 accept");
        chk("R7 accepted", int_take, 1);
        chk("R1 page zero high byte", target, 16'h0046);
        chk("R3 int clears both", {iff1, iff2}, 2'b00);
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10 pulse");
        chk("R10 one cycle", int_take, 0);

        // R9 table pointer with loaded page
        step(1, 1, 1, 0, 6, 0, 8'h12, 0, "R9 page load");
        step(1, 1, 1, 0, 1, 0, 0, 0, "R9 ei");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R9 gap");
        step(1, 1, 0, 0, 0, 0, 0, 8'h35, "R9 take");
        chk("R9 table pointer", target, 16'h1234);

        // R8 mode 1 and mode 0
        step(1, 1, 1, 0, 4, 2'd1, 0, 0, "R8 mode1");
        step(1, 1, 1, 0, 1, 0, 0, 0, "R8 ei");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R8 gap");
        step(1, 1, 0, 0, 0, 0, 0, 8'hFF, "R8 take1");
        chk("R8 mode1 target", target, 16'h0038);
        chk("R8 mode1 from_bus", from_bus, 0);
        step(1, 1, 1, 0, 4, 2'd3, 0, 0, "R11 code3");
        chk("R11 code3 ignored", im_mode, 2'd1);
        step(1, 1, 1, 0, 4, 2'd0, 0, 0, "R8 mode0");
        step(1, 1, 1, 0, 1, 0, 0, 0, "R8 ei0");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R8 gap0");
        step(1, 1, 0, 0, 0, 0, 0, 8'hC7, "R8 take0");
        chk("R8 mode0 from_bus", from_bus, 1);
        chk("R8 mode0 target", target, 16'h0000);

        // R7 busreq blocks, R6 nmi wins, R3 save/restore, R4 pv
        step(1, 1, 1, 0, 1, 0, 0, 0, "R7 ei");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R7 gap");
        step(1, 1, 0, 1, 0, 0, 0, 0, "R7 busreq");
        chk("R7 busreq blocks", int_take, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, "R5 short pulse");
        step(0, 1, 0, 1, 0, 0, 0, 0, "R5 pulse gone");
        chk("R5 no take between boundaries", nmi_take, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, "R6 both");
        chk("R6 nmi wins", {nmi_take, int_take}, 2'b10);
        chk("R5 nmi target", target, 16'h0066);
        chk("R3 nmi keeps iff2", {iff1, iff2}, 2'b01);
        step(1, 1, 1, 0, 5, 0, 0, 0, "R4 ld air");
        chk("R4 pv from iff2", pv_flag, 1);
        step(1, 1, 1, 0, 3, 0, 0, 0, "R3 retn");
        chk("R3 retn restores", iff1, 1);
        step(1, 1, 1, 0, 2, 0, 0, 0, "R2 di");
        chk("R2 di clears", {iff1, iff2}, 2'b00);
        step(1, 0, 1, 0, 0, 0, 0, 0, "R5 nmi while disabled");
        chk("R5 nmi ignores flags", nmi_take, 1);
        step(1, 1, 1, 0, 5, 0, 0, 0, "R4 ld air zero");
        chk("R4 pv zero", pv_flag, 0);

        // R12 halted no-op strobes each 4 clocks, request ends halt
        step(1, 1, 1, 0, 1, 0, 0, 0, "R12 ei");
        for (int k = 0; k < 3; k++) begin
            step(0, 1, 1, 0, 0, 0, 0, 0, "R12 idle");
            step(0, 1, (k == 2) ? 1'b0 : 1'b1, 0, 0, 0, 0, 0, "R12 idle");
            step(0, 1, (k == 2) ? 1'b0 : 1'b1, 0, 0, 0, 0, 0, "R12 idle");
            step(1, 1, (k == 2) ? 1'b0 : 1'b1, 0, 0, 0, 0, 0, "R12 halt t4");
        end
        chk("R12 halt exit accept", int_take, 1);

        // random mix: R2 R3 R5 R6 R7 R9 R10
        void'($urandom(32'h1234));
        for (int n = 0; n < 3000; n++) begin
            bit bnd, nm, it, br;
            int ev;
            bnd = ($urandom % 2) == 0;
            nm  = ($urandom % 5) != 0;
            it  = ($urandom % 3) == 0;
            br  = ($urandom % 6) == 0;
            ev  = $urandom % 9;
            if (ev > 6) ev = 0;
            step(bnd, nm, it, br, ev, 2'($urandom), 8'($urandom), 8'($urandom),
                 "R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule